// File: doc/BRIEF.md
# Sync coast window generator

This block sits in front of a pixel-clock PLL and decides when the PLL may see horizontal sync. Around each vertical sync interval the horizontal sync stream can lose pulses or gain extra ones. Any such disturbance would drag the PLL away from the line rate. The block counts horizontal sync edges between vertical sync edges and so learns how many lines make up a frame. Once the count is stable, it predicts where the next vertical sync will land. It raises a coast flag a programmed number of lines before that point and holds it until a programmed number of lines after the vertical sync. While coast is high, horizontal sync pulses are removed from the PLL reference output, so the PLL free-runs at its present frequency.

A source-select bit lets the coast flag come from an external, asynchronous coast pin instead. That pin is resynchronised before use. Both sync inputs are sampled in the block clock domain. The three configuration fields are loaded through a single write strobe and reset to internal source, two lines before and ten lines after.

Top module: `sync_coast_gen`

## Requirements
- R1: Reset drives coast_out and hsync_gated_out low and loads the settings internal source (cfg_src = 0), lines-before = 2 and lines-after = 10.
- R2: A cycle with cfg_we high loads cfg_src, cfg_pre and cfg_post. The new values govern every sync edge from the next cycle on.
- R3: The frame length is the number of hsync_in rising edges between two successive vsync_in rising edges. An hsync edge in the same cycle as a vsync edge counts toward the new frame. Prediction is enabled once two successive measured lengths match, and it is disabled by the first measurement that differs from the one before.
- R4: With prediction enabled, a previous length Lp, lines-before P where 0 < P < Lp, and lines-before plus lines-after below the frame length, internal coast rises at hsync edge number Lp-P+1 of the frame. The last P pulses before vsync are therefore blocked. P = 0 or P >= Lp gives no early window.
- R5: A vsync_in rising edge starts an after-window when lines-after Q is non-zero. The first Q hsync edges after it, including one in the same cycle, are blocked. Edge Q+1 passes and ends coast. With Q = 0, a vsync edge ends any coast and starts none.
- R6: A vsync_in edge that comes before the predicted early point, or with prediction disabled, raises coast in that cycle, and the after-window count starts from that edge.
- R7: coast_out is the selected coast one cycle later. hsync_gated_out equals hsync_in delayed by one cycle and is forced low in every cycle where the selected coast is high.
- R8: With cfg_src = 1, coast_out follows ext_coast_in after a two-flop synchronizer plus the output register (3 cycles). The internal windows then have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, active high, clk domain |
| vsync_in | input | 1 | Vertical sync, active high, clk domain |
| ext_coast_in | input | 1 | External coast request, asynchronous |
| cfg_we | input | 1 | Load strobe for the three settings |
| cfg_src | input | 1 | Coast source: 0 internal, 1 external |
| cfg_pre | input | 8 | Lines of coast before predicted vsync |
| cfg_post | input | 8 | Lines of coast after vsync |
| coast_out | output | 1 | Registered coast flag |
| hsync_gated_out | output | 1 | Registered hsync with coast pulses removed |

## Verification
A vertical sync edge and a horizontal sync edge can fall in the same cycle. The bench provokes this by raising both inputs on one clock. It then judges that the pulse is counted as the first line of the new frame: it is blocked when lines-after is non-zero, and it shifts the release to edge Q+1 of that frame. A second collision happens when a frame shortens while prediction is still enabled. The vertical edge then arrives before the early point, and the bench expects coast to start at the vertical edge and release after the programmed count. A sweep over every lines-before value from 0 to 4 and every lines-after value from 0 to 3 compares each pulse against arithmetic limits.

// File: rtl/scg_pkg.sv
package scg_pkg;
  typedef enum logic [1:0] {
    CO_IDLE = 2'd0,
    CO_PRE  = 2'd1,
    CO_POST = 2'd2
  } coast_st_t;
endpackage

// File: rtl/scg_sync.sv
module scg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/scg_rise_det.sv
module scg_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= din;
  end

  assign rise = din & ~d_q;
endmodule

// File: rtl/scg_frame_meter.sv
module scg_frame_meter #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_rise,
  input  logic              vs_rise,
  output logic [LINE_W-1:0] line_cnt,
  output logic [LINE_W-1:0] frame_len,
  output logic              locked
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic seen_vs_q;
  logic have_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt   <= '0;
      frame_len  <= '0;
      locked     <= 1'b0;
      seen_vs_q  <= 1'b0;
      have_len_q <= 1'b0;
    end else if (vs_rise) begin
      // a coincident hsync edge is the first line of the new frame
      line_cnt  <= hs_rise ? LINE_W'(1) : '0;
      seen_vs_q <= 1'b1;
      if (seen_vs_q) begin
        locked     <= have_len_q && (line_cnt == frame_len);
        frame_len  <= line_cnt;
        have_len_q <= 1'b1;
      end
    end else if (hs_rise && (line_cnt != LINE_MAX)) begin
      line_cnt <= line_cnt + LINE_W'(1);
    end
  end
endmodule

// File: rtl/scg_coast_fsm.sv
module scg_coast_fsm
  import scg_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int WIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_rise,
  input  logic              vs_rise,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] frame_len,
  input  logic              locked,
  input  logic [WIN_W-1:0]  pre_lines,
  input  logic [WIN_W-1:0]  post_lines,
  output coast_st_t         st_q,
  output logic              coast_next
);
  localparam int PAD_W = LINE_W - WIN_W;

  coast_st_t        st_n;
  logic [WIN_W-1:0] cnt_q, cnt_n;
  logic [LINE_W-1:0] pre_ext;
  logic             pre_hit;
  logic [WIN_W-1:0] post_start;

  assign pre_ext    = {{PAD_W{1'b0}}, pre_lines};
  assign post_start = hs_rise ? WIN_W'(1) : '0;
  assign pre_hit    = locked && (pre_lines != '0) && (pre_ext < frame_len)
                      && hs_rise && (line_cnt == (frame_len - pre_ext));

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      CO_IDLE: begin
        if (vs_rise) begin
          if (post_lines != '0) begin
            st_n  = CO_POST;
            cnt_n = post_start;
          end
        end else if (pre_hit) begin
          st_n = CO_PRE;
        end
      end
      CO_PRE: begin
        if (vs_rise) begin
          if (post_lines != '0) begin
            st_n  = CO_POST;
            cnt_n = post_start;
          end else begin
            st_n = CO_IDLE;
          end
        end
      end
      CO_POST: begin
        if (vs_rise) begin
          if (post_lines != '0) cnt_n = post_start;
          else                  st_n  = CO_IDLE;
        end else if (hs_rise) begin
          if (cnt_q >= post_lines) st_n  = CO_IDLE;
          else                     cnt_n = cnt_q + WIN_W'(1);
        end
      end
      default: st_n = CO_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= CO_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign coast_next = (st_n != CO_IDLE);
endmodule

// File: rtl/sync_coast_gen.sv
module sync_coast_gen
  import scg_pkg::*;
#(
  parameter int LINE_W      = 11,
  parameter int WIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_RST     = 2,
  parameter int POST_RST    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             ext_coast_in,
  input  logic             cfg_we,
  input  logic             cfg_src,
  input  logic [WIN_W-1:0] cfg_pre,
  input  logic [WIN_W-1:0] cfg_post,
  output logic             coast_out,
  output logic             hsync_gated_out
);
  logic              src_q;
  logic [WIN_W-1:0]  pre_q;
  logic [WIN_W-1:0]  post_q;
  logic              hs_rise;
  logic              vs_rise;
  logic              ext_s;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] frame_len;
  logic              locked;
  coast_st_t         st_q;
  logic              coast_int;
  logic              coast_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= 1'b0;
      pre_q  <= WIN_W'(PRE_RST);
      post_q <= WIN_W'(POST_RST);
    end else if (cfg_we) begin
      src_q  <= cfg_src;
      pre_q  <= cfg_pre;
      post_q <= cfg_post;
    end
  end

  scg_rise_det u_hs_edge (.clk(clk), .rst(rst), .din(hsync_in), .rise(hs_rise));
  scg_rise_det u_vs_edge (.clk(clk), .rst(rst), .din(vsync_in), .rise(vs_rise));

  scg_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .din(ext_coast_in), .dout(ext_s)
  );

  scg_frame_meter #(.LINE_W(LINE_W)) u_meter (
    .clk(clk), .rst(rst), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .line_cnt(line_cnt), .frame_len(frame_len), .locked(locked)
  );

  scg_coast_fsm #(.LINE_W(LINE_W), .WIN_W(WIN_W)) u_fsm (
    .clk(clk), .rst(rst), .hs_rise(hs_rise), .vs_rise(vs_rise),
    .line_cnt(line_cnt), .frame_len(frame_len), .locked(locked),
    .pre_lines(pre_q), .post_lines(post_q),
    .st_q(st_q), .coast_next(coast_int)
  );

  assign coast_sel = src_q ? ext_s : coast_int;

  always_ff @(posedge clk) begin
    if (rst) begin
      coast_out       <= 1'b0;
      hsync_gated_out <= 1'b0;
    end else begin
      coast_out       <= coast_sel;
      hsync_gated_out <= hsync_in & ~coast_sel;
    end
  end
endmodule

// File: rtl/scg_checker.sv
module scg_checker
  import scg_pkg::*;
#(
  parameter int WIN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             hsync_in,
  input logic             ext_coast_in,
  input logic             coast_out,
  input logic             hsync_gated_out,
  input logic             src_q,
  input logic [WIN_W-1:0] post_q,
  input coast_st_t        st_q,
  input logic             locked,
  input logic             vs_rise
);
  AST_GATE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    hsync_gated_out |-> $past(hsync_in)); // R7
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    coast_out |-> !hsync_gated_out); // R7
  AST_PRE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (st_q == CO_PRE && $past(st_q) == CO_IDLE) |-> $past(locked)); // R3
  AST_POST_FROM_VSYNC: assert property (@(posedge clk) disable iff (rst)
    (st_q == CO_POST && $past(st_q) != CO_POST) |-> $past(vs_rise)); // R5
  AST_EARLY_VSYNC: assert property (@(posedge clk) disable iff (rst)
    (vs_rise && post_q != '0) |=> st_q == CO_POST); // R6

  generate
    if (SYNC_STAGES == 2) begin : g_ext
      AST_EXT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $past(src_q) |-> coast_out == $past(ext_coast_in, 3)); // R8
    end
  endgenerate
endmodule

bind sync_coast_gen scg_checker #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .hsync_in(hsync_in), .ext_coast_in(ext_coast_in),
  .coast_out(coast_out), .hsync_gated_out(hsync_gated_out),
  .src_q(src_q), .post_q(post_q), .st_q(st_q), .locked(locked), .vs_rise(vs_rise)
);

// File: tb/sync_coast_gen_tb.sv
`timescale 1ns/1ps
module sync_coast_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_in = 1'b0;
  logic       vsync_in = 1'b0;
  logic       ext_coast_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_src = 1'b0;
  logic [7:0] cfg_pre = 8'd0;
  logic [7:0] cfg_post = 8'd0;
  logic       coast_out;
  logic       hsync_gated_out;

  int n_chk = 0;
  int n_fail = 0;
  // bench model of the settings and of the frame-length tracking
  int cur_lines = 0;
  int nvs = 0;
  int blen = 0;
  bit bhave = 0;
  bit blk = 0;
  int bpre = 2;
  int bpost = 10;
  bit bsrc = 0;
  bit bext = 0;

  always #2.5 clk = ~clk;

  sync_coast_gen u_dut (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .ext_coast_in(ext_coast_in), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post),
    .coast_out(coast_out), .hsync_gated_out(hsync_gated_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic cfg(input bit s, input int p, input int q);
    cfg_we = 1'b1; cfg_src = s; cfg_pre = p[7:0]; cfg_post = q[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    bsrc = s; bpre = p; bpost = q;
  endtask

  // R3: bench-side frame length and enable rule
  task automatic model_vsync();
    if (nvs > 0) begin
      blk   = bhave && (cur_lines == blen);
      blen  = cur_lines;
      bhave = 1;
    end
    nvs++;
    cur_lines = 0;
  endtask

  task automatic line(input bit with_vs, input string tag);
    int  k;
    bit  exp;
    bit  in_pre;
    string req;
    cur_lines++;
    k = cur_lines;
    in_pre = blk && (bpre > 0) && (bpre < blen) && (k > blen - bpre);
    if (bsrc) exp = bext;
    else      exp = ((bpost > 0) && (k <= bpost)) || in_pre;
    if (bsrc)                        req = {tag, "/R8"};
    else if (bpost > 0 && k <= bpost) req = {tag, "/R5"};
    else if (in_pre)                 req = {tag, "/R4"};
    else                             req = {tag, "/R7"};
    hsync_in = 1'b1;
    if (with_vs) vsync_in = 1'b1;
    @(negedge clk);
    check(hsync_gated_out == !exp, {req, " gated"}, hsync_gated_out, !exp);
    check(coast_out == exp, {req, " coast"}, coast_out, exp);
    @(negedge clk);
    hsync_in = 1'b0;
    vsync_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic vs_pulse();
    model_vsync();
    vsync_in = 1'b1;
    repeat (3) @(negedge clk);
    vsync_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input int len, input string tag);
    vs_pulse();
    for (int i = 0; i < len; i++) line(1'b0, tag);
  endtask

  // vsync and the first hsync of the frame rise in one cycle
  task automatic frame_coinc(input int len, input string tag);
    model_vsync();
    line(1'b1, tag);
    for (int i = 1; i < len; i++) line(1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(coast_out == 1'b0, "R1 coast after reset", coast_out, 0);
    check(hsync_gated_out == 1'b0, "R1 gated after reset", hsync_gated_out, 0);

    // R1 defaults: two before, ten after, internal source
    for (int f = 0; f < 5; f++) frame(16, "R1");

    // R2 new settings, R3 relock after a length change
    cfg(1'b0, 3, 2);
    for (int f = 0; f < 4; f++) frame(12, "R2");
    for (int f = 0; f < 4; f++) frame(10, "R3");

    // near-exhaustive sweep of the two window lengths
    for (int p = 0; p <= 4; p++) begin
      for (int q = 0; q <= 3; q++) begin
        cfg(1'b0, p, q);
        for (int f = 0; f < 3; f++) frame(10, "R4");
      end
    end

    // R4 boundaries: P = Lp-1 and P = Lp
    cfg(1'b0, 11, 0);
    for (int f = 0; f < 3; f++) frame(12, "R4");
    cfg(1'b0, 12, 0);
    for (int f = 0; f < 2; f++) frame(12, "R4");

    // R6 early vsync: shorter frame while prediction is enabled
    cfg(1'b0, 2, 3);
    for (int f = 0; f < 3; f++) frame(12, "R6");
    frame(8, "R6");
    frame(12, "R6");

    // R3 and R5: coincident vsync and hsync edges
    cfg(1'b0, 2, 1);
    for (int f = 0; f < 3; f++) frame_coinc(12, "R3");
    cfg(1'b0, 2, 0);
    for (int f = 0; f < 2; f++) frame_coinc(12, "R5");

    // R8 external source
    cfg(1'b1, 2, 3);
    ext_coast_in = 1'b1; bext = 1;
    repeat (4) @(negedge clk);
    check(coast_out == 1'b1, "R8 ext high", coast_out, 1);
    frame(12, "R8");
    ext_coast_in = 1'b0; bext = 0;
    repeat (4) @(negedge clk);
    check(coast_out == 1'b0, "R8 ext low", coast_out, 0);
    frame(12, "R8");
    cfg(1'b0, 2, 3);
    frame(12, "R2");
    frame(12, "R2");

    summary();
    $finish;
  end
endmodule